// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block watches five groups of external interrupt lines and turns their edges into sticky pending flags. Each group follows its own edge rule. The primary line has a software-selected polarity and is the only line that passes through a two-stage synchronizer and a digital noise filter. The filter has two selectable minimum pulse widths. A second line has a selectable polarity and no filter. A third line fires on both edges. The two quasi-interrupt groups are a rising-only line and a bank of eight active-low key inputs that fire on falling edges.

Software writes a small configuration word that holds both polarities and the filter width. It clears pending flags with a masked write. The block combines the three true-interrupt flags into one vectored request output and the two quasi flags into one flag-only output. Vectoring, arbitration and wake-up belong to other blocks.

Top module: `ext_irq_detect`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) `pend_o` is 0 and `vec_req_o` and `quasi_o` are low.
- R2: Pending bit 0 records edges of `irq_filt_i`, taken after the filter. The edge is rising when `cfg_wdata_i[0]` was written 0 and falling when it was written 1. The opposite edge sets nothing.
- R3: The filter accepts a new level of `irq_filt_i` only after the synchronized input has differed from the accepted level for N consecutive clock samples. N is SHORT_LEN (4) when `cfg_wdata_i[2]` was written 0 and LONG_LEN (128) when it was written 1. A shorter pulse sets no pending bit.
- R4: Pending bit 1 records edges of `irq_sel_i` with no filter. The edge is rising when `cfg_wdata_i[1]` is 0 and falling when it is 1.
- R5: Pending bit 2 is set by both rising and falling edges of `irq_both_i`.
- R6: Pending bit 3 is set only by rising edges of `qirq_rise_i`.
- R7: Pending bit 4 is set by a falling edge on any bit of `key_n_i`. Rising edges on the keys set nothing.
- R8: A pending bit stays set until a cycle with `clr_we_i` high and the matching `clr_mask_i` bit set. A new edge in that same cycle keeps the bit set.
- R9: `vec_req_o` is the OR of pending bits 0 to 2. `quasi_o` is the OR of pending bits 3 and 4.
- R10: On an unfiltered line, the pending bit shows after the second rising clock edge following the input change. On the filtered line it shows after edge N+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_filt_i | input | 1 | Filtered, polarity-selectable interrupt line |
| irq_sel_i | input | 1 | Unfiltered, polarity-selectable interrupt line |
| irq_both_i | input | 1 | Interrupt line sensitive to both edges |
| qirq_rise_i | input | 1 | Quasi-interrupt line, rising edge |
| key_n_i | input | NUM_KEYS | Active-low key inputs, falling edge |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | bit0 filtered-line polarity, bit1 unfiltered-line polarity, bit2 long filter |
| clr_we_i | input | 1 | Pending-clear strobe |
| clr_mask_i | input | 5 | Pending bits to clear |
| pend_o | output | 5 | Pending flags |
| vec_req_o | output | 1 | Vectored interrupt request |
| quasi_o | output | 1 | Quasi-interrupt flag |

## Verification
The assertions check the following on every cycle. The filtered level never moves before its run counter has reached the selected limit, and it only moves to the synchronized value. A pending bit never rises without a detected edge. A pending bit never drops except under a matching clear. Only the bench scenarios can show the rest: the exact latency of each line, that the wrong-polarity edge and a sub-width pulse are ignored, and that a clear in the same cycle as a new edge keeps the bit set.

// File: rtl/ext_irq_pkg.sv
// Shared types and pending-bit positions for the external interrupt detector.
package ext_irq_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_rule_e;

    localparam int NUM_SRC  = 5;
    localparam int IDX_FILT = 0;
    localparam int IDX_SEL  = 1;
    localparam int IDX_BOTH = 2;
    localparam int IDX_RISE = 3;
    localparam int IDX_KEY  = 4;
endpackage

// File: rtl/irq_glitch_filter.sv
// Synchronizes one asynchronous line and accepts a new level only after it
// has persisted for SHORT_LEN or LONG_LEN consecutive samples.
// Assumes SHORT_LEN <= LONG_LEN and both are at least 1.
module irq_glitch_filter #(
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 128,
    parameter int CNT_W     = $clog2(LONG_LEN) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_sel_i,
    input  logic raw_i,
    output logic level_o
);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LONG_LEN - 1);

    logic [1:0]       sync_q;
    logic             level_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] limit;

    assign limit   = long_sel_i ? LIM_L : LIM_S;
    assign level_o = level_q;

    // Two-stage synchronizer for the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], raw_i};
    end

    // Count consecutive mismatching samples and accept the level once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (sync_q[1] != level_q) begin
            if (run_q >= limit) begin
                level_q <= sync_q[1];
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    // R3
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q[1] != level_q && run_q < limit) |=> $stable(level_q));

    // R3
    filt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> (level_q == $past(sync_q[1])));
endmodule

// File: rtl/irq_edge_detect.sv
// Detects an edge on one level according to a runtime edge rule.
// With SAMPLE_IN set, the level is registered once before comparison.
// Otherwise the level must already be registered.
module irq_edge_detect
    import ext_irq_pkg::*;
#(
    parameter bit SAMPLE_IN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  edge_rule_e rule_i,
    input  logic       level_i,
    output logic       edge_o
);
    logic cur;
    logic prev_q;

    generate
        if (SAMPLE_IN) begin : g_sample
            logic cur_q;
            // Single sampling register for an unfiltered line.
            always_ff @(posedge clk) begin
                if (!rst_n) cur_q <= 1'b0;
                else        cur_q <= level_i;
            end
            assign cur = cur_q;
        end else begin : g_direct
            assign cur = level_i;
        end
    endgenerate

    // Hold the previous level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // Apply the edge rule to the current and previous levels.
    always_comb begin
        case (rule_i)
            EDGE_RISE: edge_o = cur & ~prev_q;
            EDGE_FALL: edge_o = ~cur & prev_q;
            EDGE_BOTH: edge_o = cur ^ prev_q;
            default:   edge_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ext_irq_detect.sv
// Top of the external interrupt detector. It holds the configuration
// register and the sticky pending flags. It instantiates one filter and a
// detector per line or key, and merges the flags into a vectored request
// and a quasi flag. Assumes all lines are idle (keys high, others low) at reset.
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int NUM_KEYS  = 8,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_filt_i,
    input  logic                irq_sel_i,
    input  logic                irq_both_i,
    input  logic                qirq_rise_i,
    input  logic [NUM_KEYS-1:0] key_n_i,
    input  logic                cfg_we_i,
    input  logic [2:0]          cfg_wdata_i,
    input  logic                clr_we_i,
    input  logic [NUM_SRC-1:0]  clr_mask_i,
    output logic [NUM_SRC-1:0]  pend_o,
    output logic                vec_req_o,
    output logic                quasi_o
);
    logic [2:0]          cfg_q;
    logic [NUM_SRC-1:0]  pend_q;
    logic [NUM_SRC-1:0]  set_vec;
    logic [NUM_KEYS-1:0] key_edge;
    logic                filt_level;

    // Configuration register: polarity bits and filter width select.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_we_i) cfg_q <= cfg_wdata_i;
    end

    irq_glitch_filter #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .long_sel_i(cfg_q[2]),
        .raw_i(irq_filt_i), .level_o(filt_level));

    irq_edge_detect #(.SAMPLE_IN(1'b0)) u_det_filt (
        .clk(clk), .rst_n(rst_n), .rule_i(cfg_q[0] ? EDGE_FALL : EDGE_RISE),
        .level_i(filt_level), .edge_o(set_vec[IDX_FILT]));

    irq_edge_detect #(.SAMPLE_IN(1'b1)) u_det_sel (
        .clk(clk), .rst_n(rst_n), .rule_i(cfg_q[1] ? EDGE_FALL : EDGE_RISE),
        .level_i(irq_sel_i), .edge_o(set_vec[IDX_SEL]));

    irq_edge_detect #(.SAMPLE_IN(1'b1)) u_det_both (
        .clk(clk), .rst_n(rst_n), .rule_i(EDGE_BOTH),
        .level_i(irq_both_i), .edge_o(set_vec[IDX_BOTH]));

    irq_edge_detect #(.SAMPLE_IN(1'b1)) u_det_rise (
        .clk(clk), .rst_n(rst_n), .rule_i(EDGE_RISE),
        .level_i(qirq_rise_i), .edge_o(set_vec[IDX_RISE]));

    generate
        for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
            irq_edge_detect #(.SAMPLE_IN(1'b1)) u_det_key (
                .clk(clk), .rst_n(rst_n), .rule_i(EDGE_FALL),
                .level_i(key_n_i[k]), .edge_o(key_edge[k]));
        end
    endgenerate

    assign set_vec[IDX_KEY] = |key_edge;

    // Sticky pending flags; a new edge wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(clr_we_i ? clr_mask_i : '0)) | set_vec;
    end

    assign pend_o    = pend_q;
    assign vec_req_o = |pend_q[IDX_BOTH:IDX_FILT];
    assign quasi_o   = |pend_q[IDX_KEY:IDX_RISE];

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
            // R8
            pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[i] && !(clr_we_i && clr_mask_i[i])) |=> pend_q[i]);
            // R2
            pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend_q[i]) |-> $past(set_vec[i]));
        end
    endgenerate

    // R9
    vec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req_o) |-> $past(|set_vec[IDX_BOTH:IDX_FILT]));
endmodule

// File: tb/sim_ext_irq_detect.sv
module sim_ext_irq_detect;
    localparam int NK = 8;
    localparam int SL = 4;
    localparam int LL = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_in = 0, b_in = 0, d_in = 0, c_in = 0;
    logic [NK-1:0] key_n = '1;
    logic cfg_we = 0;
    logic [2:0] cfg_wd = '0;
    logic clr_we = 0;
    logic [4:0] clr_mask = '0;
    logic [4:0] pend;
    logic vec_req, quasi;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ext_irq_detect #(.NUM_KEYS(NK), .SHORT_LEN(SL), .LONG_LEN(LL)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_filt_i(a_in), .irq_sel_i(b_in),
        .irq_both_i(d_in), .qirq_rise_i(c_in), .key_n_i(key_n),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .clr_we_i(clr_we),
        .clr_mask_i(clr_mask), .pend_o(pend), .vec_req_o(vec_req), .quasi_o(quasi));

    // Behavioural reference: delays, run lengths and last-seen values per line.
    int a_d1, a_d2, a_acc, a_run, a_seen;
    int b_now, b_seen, d_now, d_seen, c_now, c_seen;
    int k_now [NK];
    int k_seen [NK];
    int pol_a, pol_b, lng;
    logic [4:0] m_pend;

    always @(posedge clk) begin
        if (!rst_n) begin
            a_d1 = 0; a_d2 = 0; a_acc = 0; a_run = 0; a_seen = 0;
            b_now = 0; b_seen = 0; d_now = 0; d_seen = 0; c_now = 0; c_seen = 0;
            for (int k = 0; k < NK; k++) begin k_now[k] = 0; k_seen[k] = 0; end
            pol_a = 0; pol_b = 0; lng = 0; m_pend = '0;
        end else begin
            logic [4:0] s;
            int need;
            s = '0;
            if (a_acc != a_seen && a_acc == (pol_a ? 0 : 1)) s[0] = 1'b1;
            if (b_now != b_seen && b_now == (pol_b ? 0 : 1)) s[1] = 1'b1;
            if (d_now != d_seen) s[2] = 1'b1;
            if (c_now == 1 && c_seen == 0) s[3] = 1'b1;
            for (int k = 0; k < NK; k++) if (k_now[k] == 0 && k_seen[k] == 1) s[4] = 1'b1;
            m_pend = (m_pend & ~(clr_we ? clr_mask : 5'b0)) | s;
            need = lng ? LL : SL;
            a_seen = a_acc;
            if (a_d2 != a_acc) begin
                a_run++;
                if (a_run >= need) begin a_acc = a_d2; a_run = 0; end
            end else a_run = 0;
            a_d2 = a_d1; a_d1 = int'(a_in);
            b_seen = b_now; b_now = int'(b_in);
            d_seen = d_now; d_now = int'(d_in);
            c_seen = c_now; c_now = int'(c_in);
            for (int k = 0; k < NK; k++) begin k_seen[k] = k_now[k]; k_now[k] = int'(key_n[k]); end
            if (cfg_we) begin pol_a = int'(cfg_wd[0]); pol_b = int'(cfg_wd[1]); lng = int'(cfg_wd[2]); end
        end
    end

    // Per-cycle comparison against the reference (R9 covers the merged outputs).
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (pend !== m_pend || vec_req !== |m_pend[2:0] || quasi !== |m_pend[4:3]) begin
                failures++;
                $display("FAIL R9 per-cycle: pend=%b vec=%b quasi=%b expected pend=%b vec=%b quasi=%b",
                         pend, vec_req, quasi, m_pend, |m_pend[2:0], |m_pend[4:3]);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear(input logic [4:0] m);
        clr_we = 1; clr_mask = m;
        tick(1);
        clr_we = 0; clr_mask = '0;
    endtask

    task automatic cfg(input logic [2:0] v);
        cfg_we = 1; cfg_wd = v;
        tick(1);
        cfg_we = 0;
    endtask

    bit done = 0;

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(4);
        // R1 reset state
        chk("R1 pend", pend, 0);
        chk("R1 vec", vec_req, 0);
        chk("R1 quasi", quasi, 0);
        rst_n = 1;
        tick(3);

        // R2 / R10: rising edge, short filter, N+3 latency
        a_in = 1;
        tick(SL + 2);
        chk("R10 filt early", pend[0], 0);
        tick(1);
        chk("R2 filt rise", pend[0], 1);
        chk("R9 vec", vec_req, 1);
        clear(5'b00001);
        chk("R8 clear", pend[0], 0);
        a_in = 0;
        tick(12);
        chk("R2 fall ignored", pend[0], 0);

        // R3 short pulse rejected
        a_in = 1; tick(SL - 1); a_in = 0;
        tick(14);
        chk("R3 short glitch", pend[0], 0);

        // R3 long filter with falling polarity
        cfg(3'b101);
        a_in = 1; tick(LL + 10);
        chk("R2 rise ignored", pend[0], 0);
        a_in = 0; tick(LL - 20); a_in = 1;
        tick(LL + 10);
        chk("R3 long glitch", pend[0], 0);
        a_in = 0;
        tick(LL + 2);
        chk("R3 long early", pend[0], 0);
        tick(1);
        chk("R3 long accept", pend[0], 1);
        clear(5'b00001);

        // R4 / R10 unfiltered line
        b_in = 1; tick(1);
        chk("R10 sel early", pend[1], 0);
        tick(1);
        chk("R4 sel rise", pend[1], 1);
        b_in = 0; tick(3);
        clear(5'b00010);
        cfg(3'b111);
        b_in = 1; tick(4);
        chk("R4 rise ignored", pend[1], 0);
        b_in = 0; tick(2);
        chk("R4 sel fall", pend[1], 1);

        // R8 set and clear in the same cycle
        b_in = 1; tick(3);
        b_in = 0; tick(1);
        clear(5'b00010);
        chk("R8 set wins", pend[1], 1);
        clear(5'b00010);
        chk("R8 clear only", pend[1], 0);

        // R5 both edges
        d_in = 1; tick(2);
        chk("R5 rise", pend[2], 1);
        clear(5'b00100);
        d_in = 0; tick(2);
        chk("R5 fall", pend[2], 1);
        clear(5'b00100);
        chk("R9 vec low", vec_req, 0);

        // R6 rising-only quasi
        c_in = 1; tick(2);
        chk("R6 rise", pend[3], 1);
        chk("R9 quasi", quasi, 1);
        chk("R9 vec not quasi", vec_req, 0);
        clear(5'b01000);
        c_in = 0; tick(4);
        chk("R6 fall ignored", pend[3], 0);

        // R7 keys
        key_n[5] = 0; tick(2);
        chk("R7 key5 fall", pend[4], 1);
        clear(5'b10000);
        key_n[5] = 1; tick(4);
        chk("R7 rise ignored", pend[4], 0);
        key_n[0] = 0; tick(2);
        chk("R7 key0 fall", pend[4], 1);
        chk("R9 quasi key", quasi, 1);
        key_n[0] = 1; tick(2);
        clear(5'b11111);
        chk("R8 all cleared", pend, 0);
        tick(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule